// File: doc/BRIEF.md
# Async Receive Character Post-Processor

This block sits between an asynchronous serial receiver and the receive FIFO. Each received byte arrives with three flags: break, parity error and framing error. The block then does one of three things with it. It can forward the byte, possibly rewritten. It can drop the byte. Or it can turn it into an exception beat for the interrupt logic. A byte-wide option register sets the policy. The upper three bits select how carriage return (0x0D) and newline (0x0A) are rewritten or discarded. The next two bits select what happens when a break arrives.

The block also remembers that a break exception has been raised. The first ordinary character after that marks the end of the break. At that point, if the timeout interrupt enable is set, the beat that carries the character also carries an exception with a timeout flag. Both sides use a valid/ready handshake. The output is registered, so a character accepted in one cycle appears on the output in the next. When the output is not stalled, one character can be accepted every cycle.

Top module: `rx_char_post`

## Requirements
- R1: After reset, the option register reads 0x00, `out_valid` is low and `in_ready` is high.
- R2: A write through `cfg_wr_en` stores all eight bits of `cfg_wdata`, and `cfg_rdata` returns them from the next cycle on.
- R3: With option bit 7 clear, the bits [6:5] set the rewriting of CR and NL. A value of 00 leaves both unchanged. 01 rewrites NL to CR. 10 rewrites CR to NL. 11 swaps them in a single step, so a rewritten byte is not rewritten back. All other bytes pass unchanged.
- R4: With option bit 7 set, every received CR is dropped and bit 6 has no effect. Bit 5 still rewrites NL to CR.
- R5: A break is handled according to option bits [4:3]. Code 00 and code 10 emit an exception beat with `out_exc`=1, `out_tmo`=0, `out_chr`=0 and data 0x00. Code 01 emits a character beat carrying 0x00. Code 11 emits nothing.
- R6: A break exception arms an end-of-break state. The first later accepted non-break byte clears that state. If `tmo_int_en` is high at that point, the beat also carries `out_exc`=1 and `out_tmo`=1. This happens even when the byte itself is dropped, in which case `out_chr`=0 and the data is 0x00. It happens only once per break.
- R7: If `tmo_int_en` is low when the first non-break byte after a break exception arrives, no timeout flag is raised. The state is still cleared, so setting the enable later raises nothing.
- R8: A non-break byte with a parity or framing error is forwarded without CR/NL rewriting, with `out_err`=1 and `out_chr`=1.
- R9: While `out_valid` is high and `out_ready` is low, every output field holds its value and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R10: A byte accepted on a clock edge produces its beat, if it produces one, on the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Option register write strobe |
| cfg_wdata | input | 8 | Option register write data |
| cfg_rdata | output | 8 | Option register contents |
| tmo_int_en | input | 1 | Enable for the end-of-break timeout exception |
| in_valid | input | 1 | Received byte available |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_data | input | 8 | Received byte |
| in_brk | input | 1 | Byte represents a break condition |
| in_perr | input | 1 | Parity error on the byte |
| in_ferr | input | 1 | Framing error on the byte |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Delivered character (0x00 on exception-only beats) |
| out_chr | output | 1 | Beat carries a character for the FIFO |
| out_exc | output | 1 | Beat carries an exception |
| out_tmo | output | 1 | Exception is an end-of-break timeout |
| out_err | output | 1 | Delivered character had a parity or framing error |

## Verification
The assertions check the following properties on every cycle:
- the output holds steady and input acceptance stops under back-pressure;
- a CR is never delivered while CR discard is selected;
- a silently dropped break leaves no beat;
- an error byte comes through one cycle later with its value untouched;
- every exception beat has a consistent shape.

Some behaviours are only shown by the bench's directed scenarios: the full eight-way rewrite matrix, the four break codes, and the arming and single firing of the end-of-break timeout. The bench also shows how the timeout interacts with the enable and with a dropped CR. Each of these depends on a history of writes and characters.

// File: rtl/rx_post_pkg.sv
// Package: shared constants and types for the receive post-processor.
// Assumes 8-bit characters; option layout is fixed by the register map.
package rx_post_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned BRK_W  = 2;

    localparam logic [CHAR_W-1:0] CODE_CR  = CHAR_W'(8'h0D);
    localparam logic [CHAR_W-1:0] CODE_NL  = CHAR_W'(8'h0A);
    localparam logic [CHAR_W-1:0] CODE_NUL = '0;

    typedef enum logic [BRK_W-1:0] {
        BRK_RAISE = 2'b00,
        BRK_NULL  = 2'b01,
        BRK_RSVD  = 2'b10,
        BRK_DROP  = 2'b11
    } brk_act_e;

    // Option register layout, most significant field first.
    typedef struct packed {
        logic             ign_cr;
        logic             cr2nl;
        logic             nl2cr;
        logic [BRK_W-1:0] brk;
        logic [2:0]       err_opt;
    } opt_t;

    // One output beat.
    typedef struct packed {
        logic              chr;
        logic              exc;
        logic              tmo;
        logic              err;
        logic [CHAR_W-1:0] data;
    } beat_t;
endpackage

// File: rtl/rx_opt_reg.sv
// Option register: byte-wide storage, read back continuously.
// Assumes the write strobe is single-cycle qualified by the caller.
module rx_opt_reg
    import rx_post_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wdata,
    output opt_t              opt_q
);
    // Load the option byte on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q <= '0;
        end else if (wr_en) begin
            opt_q <= opt_t'(wdata);
        end
    end
endmodule

// File: rtl/rx_crnl_xlate.sv
// CR/NL rewrite: one-step rewrite or discard of a clean received byte.
// Assumes the byte carries no break or error flag; the caller selects.
module rx_crnl_xlate
    import rx_post_pkg::*;
(
    input  logic              ign_cr,
    input  logic              cr2nl,
    input  logic              nl2cr,
    input  logic [CHAR_W-1:0] din,
    output logic              keep,
    output logic [CHAR_W-1:0] dout
);
    // Single-step mapping: each byte is tested once against its original value.
    always_comb begin
        keep = 1'b1;
        dout = din;
        if (din == CODE_CR) begin
            if (ign_cr) begin
                keep = 1'b0;
            end else if (cr2nl) begin
                dout = CODE_NL;
            end
        end else if (din == CODE_NL) begin
            if (nl2cr) begin
                dout = CODE_CR;
            end
        end
    end
endmodule

// File: rtl/rx_char_policy.sv
// Per-character policy: picks forward, drop or exception for one byte and
// reports whether the end-of-break state must be armed or cleared.
// Assumes the caller gates the arm/clear requests with the accept strobe.
module rx_char_policy
    import rx_post_pkg::*;
(
    input  logic              ign_cr,
    input  logic              cr2nl,
    input  logic              nl2cr,
    input  brk_act_e          brk_act,
    input  logic              tmo_en,
    input  logic              pend,
    input  logic [CHAR_W-1:0] din,
    input  logic              brk,
    input  logic              perr,
    input  logic              ferr,
    output logic              emit,
    output beat_t             beat,
    output logic              arm,
    output logic              disarm
);
    logic              x_keep;
    logic [CHAR_W-1:0] x_data;
    logic              bad;

    rx_crnl_xlate u_xlate (
        .ign_cr (ign_cr),
        .cr2nl  (cr2nl),
        .nl2cr  (nl2cr),
        .din    (din),
        .keep   (x_keep),
        .dout   (x_data)
    );

    // Any line error bypasses the rewrite.
    assign bad = perr | ferr;

    // Decide what this byte becomes.
    always_comb begin
        emit   = 1'b0;
        beat   = '0;
        arm    = 1'b0;
        disarm = 1'b0;
        if (brk) begin
            unique case (brk_act)
                BRK_NULL: begin
                    emit      = 1'b1;
                    beat.chr  = 1'b1;
                    beat.data = CODE_NUL;
                end
                BRK_DROP: begin
                    emit = 1'b0;
                end
                default: begin
                    emit     = 1'b1;
                    beat.exc = 1'b1;
                    arm      = 1'b1;
                end
            endcase
        end else begin
            disarm = pend;
            if (bad) begin
                emit      = 1'b1;
                beat.chr  = 1'b1;
                beat.err  = 1'b1;
                beat.data = din;
            end else if (x_keep) begin
                emit      = 1'b1;
                beat.chr  = 1'b1;
                beat.data = x_data;
            end
            if (pend && tmo_en) begin
                emit     = 1'b1;
                beat.exc = 1'b1;
                beat.tmo = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rx_brk_track.sv
// End-of-break tracker: one flag, armed by a break exception and cleared
// by the first non-break byte. Arm wins if both are requested.
module rx_brk_track (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    output logic pend
);
    // Hold the break-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (arm) begin
            pend <= 1'b1;
        end else if (disarm) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_out_stage.sv
// Output register: one-entry valid/ready stage with registered data.
// Assumes load is only asserted when can_take is high.
module rx_out_stage
    import rx_post_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  beat_t beat_i,
    input  logic  out_ready,
    output logic  out_valid,
    output beat_t beat_q,
    output logic  can_take
);
    // Space exists when empty or when the held beat leaves this cycle.
    assign can_take = !out_valid || out_ready;

    // Capture a new beat or retire the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            beat_q    <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            beat_q    <= beat_i;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_char_post.sv
// Receive post-processor top: option register, per-byte policy,
// end-of-break tracker and a registered output stage.
// Assumes in_brk, in_perr and in_ferr are qualified by in_valid.
module rx_char_post
    import rx_post_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CHAR_W-1:0] cfg_wdata,
    output logic [CHAR_W-1:0] cfg_rdata,
    input  logic              tmo_int_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_brk,
    input  logic              in_perr,
    input  logic              in_ferr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_chr,
    output logic              out_exc,
    output logic              out_tmo,
    output logic              out_err
);
    opt_t  opt_q;
    logic  pend;
    logic  emit, arm, disarm;
    logic  accept;
    beat_t beat_n;
    beat_t beat_q;

    rx_opt_reg u_opt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .opt_q (opt_q)
    );

    // Whole option byte is visible for read-back.
    assign cfg_rdata = opt_q;

    rx_char_policy u_policy (
        .ign_cr  (opt_q.ign_cr),
        .cr2nl   (opt_q.cr2nl),
        .nl2cr   (opt_q.nl2cr),
        .brk_act (brk_act_e'(opt_q.brk)),
        .tmo_en  (tmo_int_en),
        .pend    (pend),
        .din     (in_data),
        .brk     (in_brk),
        .perr    (in_perr),
        .ferr    (in_ferr),
        .emit    (emit),
        .beat    (beat_n),
        .arm     (arm),
        .disarm  (disarm)
    );

    // A byte is consumed when offered and the stage has room.
    assign accept = in_valid && in_ready;

    rx_brk_track u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (accept && arm),
        .disarm (accept && disarm),
        .pend   (pend)
    );

    rx_out_stage u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && emit),
        .beat_i    (beat_n),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat_q    (beat_q),
        .can_take  (in_ready)
    );

    // Unpack the held beat onto the output pins.
    assign out_data = beat_q.data;
    assign out_chr  = beat_q.chr;
    assign out_exc  = beat_q.exc;
    assign out_tmo  = beat_q.tmo;
    assign out_err  = beat_q.err;
endmodule

// File: rtl/rx_char_post_chk.sv
// Checker for rx_char_post: port-level temporal properties, bound below.
module rx_char_post_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ign_cr,
    input logic [1:0] brk_act,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       in_brk,
    input logic       in_perr,
    input logic       in_ferr,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_chr,
    input logic       out_exc,
    input logic       out_tmo,
    input logic       out_err
);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chr)
            && $stable(out_exc) && $stable(out_tmo) && $stable(out_err));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R8
    err_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_brk && (in_perr || in_ferr)
            |=> out_valid && out_chr && out_err && out_data == $past(in_data));

    // R4
    cr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_brk && !in_perr && !in_ferr && ign_cr
            && in_data == 8'h0D |=> !(out_valid && out_chr));

    // R5
    brk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_brk && brk_act == 2'b11 |=> !out_valid);

    // R5
    exc_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_exc && !out_tmo |-> !out_chr && !out_err && out_data == 8'h00);

    // R6
    tmo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_tmo |-> out_exc);
endmodule

bind rx_char_post rx_char_post_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ign_cr    (cfg_rdata[7]),
    .brk_act   (cfg_rdata[4:3]),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_brk    (in_brk),
    .in_perr   (in_perr),
    .in_ferr   (in_ferr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_chr   (out_chr),
    .out_exc   (out_exc),
    .out_tmo   (out_tmo),
    .out_err   (out_err)
);

// File: tb/rx_char_post_tb.sv
// Directed bench for rx_char_post: one task per scenario.
module rx_char_post_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CR = 8'h0D;
    localparam logic [7:0] NL = 8'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tmo_int_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_brk = 1'b0;
    logic       in_perr = 1'b0;
    logic       in_ferr = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_chr, out_exc, out_tmo, out_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_char_post u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .tmo_int_en (tmo_int_en),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_brk     (in_brk),
        .in_perr    (in_perr),
        .in_ferr    (in_ferr),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_chr    (out_chr),
        .out_exc    (out_exc),
        .out_tmo    (out_tmo),
        .out_err    (out_err)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_opt(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Offer one byte with the output always ready; sample the beat one edge later (R10).
    task automatic xfer(input string tag, input logic [7:0] d, input logic b, input logic pe,
                        input logic fe, input logic ev, input logic ec, input logic ex,
                        input logic et, input logic ee, input logic [7:0] ed);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_brk   = b;
        in_perr  = pe;
        in_ferr  = fe;
        @(negedge clk);
        in_valid = 1'b0;
        in_brk   = 1'b0;
        in_perr  = 1'b0;
        in_ferr  = 1'b0;
        if (ev)
            chk(tag, "beat {valid,chr,exc,tmo,err,data}",
                32'({out_valid, out_chr, out_exc, out_tmo, out_err, out_data}),
                32'({1'b1, ec, ex, et, ee, ed}));
        else
            chk(tag, "no beat", 32'(out_valid), 32'(0));
    endtask

    task automatic t_reset();
        chk("R1", "out_valid after reset", 32'(out_valid), 32'(0));
        chk("R1", "option after reset", 32'(cfg_rdata), 32'(0));
        chk("R1", "in_ready after reset", 32'(in_ready), 32'(1));
    endtask

    task automatic t_cfg_rw();
        set_opt(8'hA5);
        chk("R2", "read-back A5", 32'(cfg_rdata), 32'hA5);
        set_opt(8'h5A);
        chk("R2", "read-back 5A", 32'(cfg_rdata), 32'h5A);
        set_opt(8'h00);
    endtask

    task automatic t_rewrite();
        set_opt(8'h00);
        xfer("R3", CR, 0, 0, 0, 1, 1, 0, 0, 0, CR);
        xfer("R3", NL, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        xfer("R3", 8'h41, 0, 0, 0, 1, 1, 0, 0, 0, 8'h41);
        set_opt(8'h20);
        xfer("R3", NL, 0, 0, 0, 1, 1, 0, 0, 0, CR);
        xfer("R3", CR, 0, 0, 0, 1, 1, 0, 0, 0, CR);
        set_opt(8'h40);
        xfer("R3", CR, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        xfer("R3", NL, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        set_opt(8'h60);
        xfer("R3", CR, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        xfer("R3", NL, 0, 0, 0, 1, 1, 0, 0, 0, CR);
        xfer("R3", 8'h7E, 0, 0, 0, 1, 1, 0, 0, 0, 8'h7E);
    endtask

    task automatic t_discard();
        set_opt(8'h80);
        xfer("R4", CR, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        xfer("R4", NL, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        set_opt(8'hC0);
        xfer("R4", CR, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        xfer("R4", NL, 0, 0, 0, 1, 1, 0, 0, 0, NL);
        set_opt(8'hA0);
        xfer("R4", CR, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        xfer("R4", NL, 0, 0, 0, 1, 1, 0, 0, 0, CR);
        set_opt(8'hE0);
        xfer("R4", CR, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        xfer("R4", NL, 0, 0, 0, 1, 1, 0, 0, 0, CR);
    endtask

    task automatic t_break();
        tmo_int_en = 1'b0;
        set_opt(8'h08);
        xfer("R5", 8'h00, 1, 0, 0, 1, 1, 0, 0, 0, 8'h00);
        set_opt(8'h18);
        xfer("R5", 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        set_opt(8'h10);
        xfer("R5", 8'h00, 1, 0, 0, 1, 0, 1, 0, 0, 8'h00);
        set_opt(8'h00);
        xfer("R5", 8'h00, 1, 0, 0, 1, 0, 1, 0, 0, 8'h00);
        xfer("R5", 8'h30, 0, 0, 0, 1, 1, 0, 0, 0, 8'h30);
    endtask

    task automatic t_end_of_break();
        set_opt(8'h00);
        tmo_int_en = 1'b1;
        xfer("R6", 8'h00, 1, 0, 0, 1, 0, 1, 0, 0, 8'h00);
        xfer("R6", 8'h42, 0, 0, 0, 1, 1, 1, 1, 0, 8'h42);
        xfer("R6", 8'h43, 0, 0, 0, 1, 1, 0, 0, 0, 8'h43);
        set_opt(8'h80);
        xfer("R6", 8'h00, 1, 0, 0, 1, 0, 1, 0, 0, 8'h00);
        xfer("R6", CR, 0, 0, 0, 1, 0, 1, 1, 0, 8'h00);
        xfer("R6", CR, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic t_tmo_off();
        set_opt(8'h00);
        tmo_int_en = 1'b0;
        xfer("R7", 8'h00, 1, 0, 0, 1, 0, 1, 0, 0, 8'h00);
        xfer("R7", 8'h44, 0, 0, 0, 1, 1, 0, 0, 0, 8'h44);
        tmo_int_en = 1'b1;
        xfer("R7", 8'h45, 0, 0, 0, 1, 1, 0, 0, 0, 8'h45);
    endtask

    task automatic t_errors();
        tmo_int_en = 1'b0;
        set_opt(8'h60);
        xfer("R8", CR, 0, 1, 0, 1, 1, 0, 0, 1, CR);
        xfer("R8", NL, 0, 0, 1, 1, 1, 0, 0, 1, NL);
        set_opt(8'h80);
        xfer("R8", CR, 0, 1, 1, 1, 1, 0, 0, 1, CR);
    endtask

    task automatic t_stall();
        set_opt(8'h00);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 8'h58;
        @(negedge clk);
        in_data = 8'h59;
        chk("R9", "first beat held", 32'({out_valid, out_data}), 32'({1'b1, 8'h58}));
        chk("R9", "in_ready while stalled", 32'(in_ready), 32'(0));
        @(negedge clk);
        chk("R9", "beat still held", 32'({out_valid, out_data}), 32'({1'b1, 8'h58}));
        chk("R9", "in_ready still low", 32'(in_ready), 32'(0));
        out_ready = 1'b1;
        #1;
        chk("R9", "in_ready on release", 32'(in_ready), 32'(1));
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "second beat next cycle", 32'({out_valid, out_data}), 32'({1'b1, 8'h59}));
        @(negedge clk);
        chk("R9", "drained", 32'(out_valid), 32'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_rw();
        t_rewrite();
        t_discard();
        t_break();
        t_end_of_break();
        t_tmo_off();
        t_errors();
        t_stall();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule